// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block controls an eight-pin general-purpose port that has no direction register. Each pin is either pulled hard to ground or let go to a weak pull-up. A pin the host wants to use as an input is simply written with a one. An external source can then pull it low, and the level can be read back. The block sits behind a byte-oriented two-wire serial slave front end. That front end hands it a write strobe with a data byte after each acknowledged byte of a write transaction. It raises a capture strobe at the acknowledge point of a read. It also passes on the raw serial clock level.

For every pin the block drives three pad controls: a strong low driver, a weak pull-up enable, and a short-lived strong pull-up enable. The strong pull-up gives fast rising edges into heavy loads. A write that takes a pin from low to high turns it on. The next falling edge of the serial clock turns it off, after that clock has passed through a synchronizer. On a read capture the block samples the synchronized pin levels, not its own register, and holds that byte until the next capture.

Top module: `qb_port`

## Requirements
- R1: After reset every pin is released: all strong low drives are 0, all weak pull-up enables are 1, all strong pull-up enables are 0, and the read byte is 8'hFF.
- R2: A bit written 0 turns on that pin's strong low drive (bit i of the data byte controls pin i) and turns off its weak pull-up. The change shows on the clock edge that samples the write strobe.
- R3: A bit written 1 turns off that pin's low drive and turns on its weak pull-up, on the same edge.
- R4: A write arms the strong pull-up of every pin whose bit goes from 0 to 1, on the edge that samples the strobe. The strong pull-up never turns on without a write.
- R5: A pin written 0 never has its strong pull-up on. A write of 0 also cancels an assist already armed on that pin.
- R6: Armed strong pull-ups turn off on the third rising clock edge after the serial clock input falls, which allows for two synchronizer stages and one edge detector. They are still on after the first edge. A rising serial clock has no effect.
- R7: Write strobes on consecutive cycles each update the pins in turn. Each byte arms its bits relative to the byte before it.
- R8: A capture strobe loads the read byte with the pin input levels, synchronized through two stages. A pin held low from outside reads 0 even when its register bit is 1.
- R9: Between capture strobes the read byte holds, whatever the pins do.
- R10: With the default setting, a pin that is already high and is written 1 again is not armed anew.
- R11: When a write and a detected serial clock fall meet on the same edge, the bits the write arms stay on and every other armed bit turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | Write strobe, one cycle per acknowledged data byte |
| wr_data | input | 8 | Byte to load into the port register |
| rd_stb | input | 1 | Capture strobe for the pin levels |
| scl_in | input | 1 | Raw serial clock level |
| pin_in | input | 8 | Pin input levels from the pads |
| drive_low | output | 8 | Strong low driver enable per pin |
| weak_pu_en | output | 8 | Weak pull-up enable per pin |
| strong_pu_en | output | 8 | Momentary strong pull-up enable per pin |
| rd_data | output | 8 | Last captured pin levels |

## Verification
The assertions check the following on every cycle. The low drives follow each written byte one edge later. No pin ever has its strong pull-up and its low driver on together. Strong pull-ups only turn on after a write, and exactly on the bits that rose. The read byte holds between captures. The bench scenarios are what show the timing of the assist's release through the serial clock synchronizer, and what happens when a write and a clock fall meet on one edge. They also show that a read returns the pin levels rather than the register when a pin is held low from outside.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int unsigned QB_PINS = 8;

  typedef struct packed {
    logic drv_low;
    logic weak_pu;
    logic strong_pu;
  } qb_pad_ctl_t;
endpackage

// File: rtl/qb_reset_sync.sv
module qb_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/qb_sync.sv
module qb_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qb_pin_cell.sv
module qb_pin_cell
  import qb_pkg::*;
#(
  parameter bit REARM_HIGH = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_bit,
  input  logic        scl_fall,
  output qb_pad_ctl_t pad
);
  logic out_q, out_d;
  logic assist_q, assist_d;
  logic arm;

  generate
    if (REARM_HIGH) begin : g_rearm
      assign arm = wr_en & wr_bit;
    end else begin : g_rise_only
      assign arm = wr_en & wr_bit & ~out_q;
    end
  endgenerate

  always_comb begin
    out_d = wr_en ? wr_bit : out_q;
    if (arm)                  assist_d = 1'b1;
    else if (wr_en & ~wr_bit) assist_d = 1'b0;
    else if (scl_fall)        assist_d = 1'b0;
    else                      assist_d = assist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= 1'b1;
      assist_q <= 1'b0;
    end else begin
      out_q    <= out_d;
      assist_q <= assist_d;
    end
  end

  assign pad.drv_low   = ~out_q;
  assign pad.weak_pu   = out_q;
  assign pad.strong_pu = assist_q;
endmodule

// File: rtl/qb_port.sv
module qb_port
  import qb_pkg::*;
#(
  parameter int unsigned PINS        = QB_PINS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          REARM_HIGH  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [PINS-1:0] wr_data,
  input  logic            rd_stb,
  input  logic            scl_in,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] drive_low,
  output logic [PINS-1:0] weak_pu_en,
  output logic [PINS-1:0] strong_pu_en,
  output logic [PINS-1:0] rd_data
);
  localparam logic [PINS-1:0] ALL_HIGH = '1;

  logic            core_rst_n;
  logic            scl_s, scl_prev_q;
  logic            scl_fall;
  logic [PINS-1:0] pin_s;
  logic [PINS-1:0] rd_q, rd_d;
  qb_pad_ctl_t     pad [PINS];

  qb_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_out(core_rst_n)
  );

  qb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(core_rst_n), .d(scl_in), .q(scl_s)
  );

  qb_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(ALL_HIGH)) u_pin_sync (
    .clk(clk), .rst_n(core_rst_n), .d(pin_in), .q(pin_s)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) scl_prev_q <= 1'b1;
    else             scl_prev_q <= scl_s;
  end

  assign scl_fall = scl_prev_q & ~scl_s;

  genvar gi;
  generate
    for (gi = 0; gi < PINS; gi++) begin : g_pin
      qb_pin_cell #(.REARM_HIGH(REARM_HIGH)) u_cell (
        .clk(clk), .rst_n(core_rst_n), .wr_en(wr_stb),
        .wr_bit(wr_data[gi]), .scl_fall(scl_fall), .pad(pad[gi])
      );
      assign drive_low[gi]    = pad[gi].drv_low;
      assign weak_pu_en[gi]   = pad[gi].weak_pu;
      assign strong_pu_en[gi] = pad[gi].strong_pu;
    end
  endgenerate

  always_comb rd_d = rd_stb ? pin_s : rd_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) rd_q <= ALL_HIGH;
    else             rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/qb_port_checker.sv
module qb_port_checker #(
  parameter int unsigned PINS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_stb,
  input logic [PINS-1:0] wr_data,
  input logic            rd_stb,
  input logic [PINS-1:0] drive_low,
  input logic [PINS-1:0] strong_pu_en,
  input logic [PINS-1:0] rd_data
);
  a_r2_low_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> drive_low == ~$past(wr_data));

  a_r5_no_assist_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_pu_en & drive_low) == '0);

  a_r4_assist_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> (strong_pu_en & ~$past(strong_pu_en)) == '0);

  a_r4_rising_bits_armed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (strong_pu_en & ($past(wr_data) & $past(drive_low)))
               == ($past(wr_data) & $past(drive_low)));

  a_r9_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

bind qb_port qb_port_checker #(.PINS(PINS)) u_checker (
  .clk(clk), .rst_n(core_rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
  .rd_stb(rd_stb), .drive_low(drive_low), .strong_pu_en(strong_pu_en),
  .rd_data(rd_data)
);

// File: tb/qb_port_tb.sv
`timescale 1ns/1ps
module qb_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb, rd_stb, scl_in;
  logic [7:0] wr_data, pin_in;
  logic [7:0] drive_low, weak_pu_en, strong_pu_en, rd_data;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  qb_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .scl_in(scl_in), .pin_in(pin_in),
    .drive_low(drive_low), .weak_pu_en(weak_pu_en),
    .strong_pu_en(strong_pu_en), .rd_data(rd_data)
  );

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_byte(logic [7:0] b);
    wr_stb = 1'b1; wr_data = b;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check8("R1", "drive_low", drive_low, 8'h00);
    check8("R1", "weak_pu_en", weak_pu_en, 8'hFF);
    check8("R1", "strong_pu_en", strong_pu_en, 8'h00);
    check8("R1", "rd_data", rd_data, 8'hFF);
  endtask

  task automatic t_mixed_write;
    write_byte(8'hA5);
    check8("R2", "drive_low", drive_low, 8'h5A);
    check8("R3", "weak_pu_en", weak_pu_en, 8'hA5);
    check8("R10", "strong_pu_en high bits", strong_pu_en, 8'h00);
  endtask

  task automatic t_rise_and_release;
    write_byte(8'hFF);
    check8("R4", "strong_pu_en armed", strong_pu_en, 8'h5A);
    scl_in = 1'b1; idle(3);
    check8("R6", "strong_pu_en scl high", strong_pu_en, 8'h5A);
    scl_in = 1'b0;
    @(negedge clk);
    check8("R6", "strong_pu_en after 1 edge", strong_pu_en, 8'h5A);
    idle(2);
    check8("R6", "strong_pu_en after 3 edges", strong_pu_en, 8'h00);
    scl_in = 1'b1; idle(4);
    check8("R6", "strong_pu_en scl rise", strong_pu_en, 8'h00);
  endtask

  task automatic t_zero_cancels;
    write_byte(8'h00);
    check8("R5", "strong_pu_en all low", strong_pu_en, 8'h00);
    write_byte(8'hFF);
    check8("R4", "strong_pu_en all rise", strong_pu_en, 8'hFF);
    write_byte(8'h0F);
    check8("R5", "strong_pu_en cancelled", strong_pu_en, 8'h0F);
    check8("R2", "drive_low", drive_low, 8'hF0);
    scl_in = 1'b0; idle(3); scl_in = 1'b1; idle(3);
    check8("R6", "strong_pu_en cleared", strong_pu_en, 8'h00);
  endtask

  task automatic t_burst;
    write_byte(8'h00);
    wr_stb = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    check8("R7", "drive_low byte 1", drive_low, 8'hC3);
    check8("R7", "strong_pu_en byte 1", strong_pu_en, 8'h3C);
    wr_data = 8'hC3;
    @(negedge clk);
    wr_stb = 1'b0;
    check8("R7", "drive_low byte 2", drive_low, 8'h3C);
    check8("R7", "strong_pu_en byte 2", strong_pu_en, 8'hC3);
  endtask

  task automatic t_read;
    pin_in = 8'hF0; idle(3);
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    check8("R8", "rd_data pins", rd_data, 8'hF0);
    pin_in = 8'h0F; idle(5);
    check8("R9", "rd_data held", rd_data, 8'hF0);
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    check8("R8", "rd_data new pins", rd_data, 8'h0F);
    pin_in = 8'hFF; idle(3);
  endtask

  task automatic t_collision;
    write_byte(8'h00);
    write_byte(8'h0F);
    check8("R4", "strong_pu_en low nibble", strong_pu_en, 8'h0F);
    scl_in = 1'b0;
    idle(2);
    write_byte(8'hFF);
    check8("R11", "strong_pu_en collision", strong_pu_en, 8'hF0);
    scl_in = 1'b1; idle(3);
  endtask

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; scl_in = 1'b1;
    wr_data = 8'h00; pin_in = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_mixed_write();
    t_rise_and_release();
    t_zero_cancels();
    t_burst();
    t_read();
    t_collision();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule